// File: doc/BRIEF.md
# I2C Read-Path Serial Memory Target

This block is an I2C target that behaves like a 1024 x 8 serial memory seen from its read side. It watches SCL and SDA with a fast system clock that runs at least eight times the bus clock. It finds START, repeated START and STOP conditions and decodes the device-select byte. On a write select it takes a single word-address byte. Read bytes go out MSB first through an open-drain pull-low enable. Write data after the word address is not stored.

The upper two memory-address bits come from the device-select byte and are not compared against pins. A random read consists of a write select, a word address, a repeated START and a read select. A current-address read is a read select with no address. One internal address pointer survives STOP, so a current-address read returns the byte after the last one sent. The master keeps a sequential read going by pulling ACK low. A test-side preload port fills the storage array.

Top module: `i2c_rdmem_target`

## Requirements
- R1: After reset the SDA pull-low enable is 0, and the address pointer is 0, so a current-address read as the first transaction returns the byte at address 0x000.
- R2: Select-byte layout: bits [7:4] are the identifier, bit 3 is ignored, bits [2:1] are memory-address bits [9:8], and bit 0 is direction (1 = read). The target acknowledges by holding SDA low through the ninth clock. When bits [7:4] are not 1010 it does not acknowledge, drives nothing until the next START, and leaves its pointer unchanged.
- R3: A random read returns the byte at address {select[2:1], word byte}, MSB first, and acknowledges both the write select and the word byte. The sequence is START, write select, word byte, repeated START, read select.
- R4: A current-address read returns the byte at the address that follows the last byte sent. The pointer is kept across STOP.
- R5: When the master drives ACK low after D0, the target sends the byte at the next address.
- R6: The pointer wraps from 0x3FF to 0x000 during sequential and current-address reads.
- R7: After a master NACK, the target drives SDA no more until the next START, even if SCL keeps clocking.
- R8: The SDA enable changes only while SCL is low, and SDA is released during the master's ACK bit.
- R9: When the preload strobe is high, a preload write stores the data byte at the preload address on the clock edge. A later read returns that byte.
- R10: The page bits and bit 3 of a read select are ignored, and a current-address read still uses the pointer. Bit 3 of a write select is ignored.
- R11: A START in the middle of a byte stops the decode of that byte and begins a new select-byte decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| pl_we_i | input | 1 | Preload write strobe |
| pl_addr_i | input | 10 | Preload address |
| pl_data_i | input | 8 | Preload data byte |

## Verification
A wrong pointer shows up in the first data byte of the next current-address read, and one address step moves the byte read back. A wrong bit count or a wrong state shows up in the very next acknowledge slot: the master sees a missing ACK, or finds SDA held low when it should be free. A drive enable that changes while SCL is high would appear on the wire as a false START or STOP. The bench flags that within the same bit period.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  localparam int          BYTE_W = 8;
  localparam logic [3:0]  SEL_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;

  function automatic logic sel_id_ok(input logic [BYTE_W-1:0] sel);
    return sel[7:4] == SEL_ID;
  endfunction

  function automatic logic sel_is_read(input logic [BYTE_W-1:0] sel);
    return sel[0];
  endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] clean;
  logic [NLINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign clean[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= clean;
  end

  assign scl_s    = clean[1];
  assign sda_s    = clean[0];
  assign scl_rise = clean[1] & ~prev[1];
  assign scl_fall = ~clean[1] & prev[1];
  assign start_ev = clean[1] & prev[1] & prev[0] & ~clean[0];
  assign stop_ev  = clean[1] & prev[1] & ~prev[0] & clean[0];

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
  import i2cmem_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic              sda_oe
);

  localparam int PAGE_W = AW - BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(BYTE_W);

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [PAGE_W-1:0] sel_page(input logic [BYTE_W-1:0] sel);
    return sel[PAGE_W:1];
  endfunction

  function automatic logic [AW-1:0] join_addr(input logic [PAGE_W-1:0] pg,
                                              input logic [BYTE_W-1:0] w);
    return {pg, w};
  endfunction

  tgt_state_e        st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic [AW-1:0]     ptr;
  logic [PAGE_W-1:0] page;
  logic              rd_dir;
  logic              mack;
  logic              oe;

  // named internal events
  logic bus_evt, byte_done, sel_end, word_load, ptr_step, tx_load;
  assign bus_evt   = start_ev | stop_ev;
  assign byte_done = bitcnt == FULL;
  assign sel_end   = !bus_evt && st == ST_SEL && scl_fall && byte_done;
  assign word_load = !bus_evt && st == ST_WORD && scl_fall && byte_done;
  assign ptr_step  = !bus_evt && st == ST_TX && scl_fall && bitcnt == LAST_TX;
  assign tx_load   = !bus_evt && scl_fall &&
                     ((st == ST_SEL_ACK && rd_dir) || (st == ST_TX_ACK && mack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txreg  <= '0;
      ptr    <= '0;
      page   <= '0;
      rd_dir <= 1'b0;
      mack   <= 1'b0;
      oe     <= 1'b0;
    end else if (start_ev) begin
      st     <= ST_SEL;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else if (stop_ev) begin
      st     <= ST_IDLE;
      oe     <= 1'b0;
    end else begin
      if (tx_load) begin
        st     <= ST_TX;
        txreg  <= rd_data;
        oe     <= ~rd_data[BYTE_W-1];
        bitcnt <= '0;
      end
      unique case (st)
        ST_SEL, ST_WORD: begin
          if (scl_rise && !byte_done) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end
          if (sel_end) begin
            if (sel_id_ok(shreg)) begin
              st     <= ST_SEL_ACK;
              oe     <= 1'b1;
              rd_dir <= sel_is_read(shreg);
              if (!sel_is_read(shreg)) page <= sel_page(shreg);
            end else begin
              st <= ST_IDLE;
            end
          end
          if (word_load) begin
            st  <= ST_WORD_ACK;
            oe  <= 1'b1;
            ptr <= join_addr(page, shreg);
          end
        end
        ST_SEL_ACK: begin
          if (scl_fall && !rd_dir) begin
            st     <= ST_WORD;
            oe     <= 1'b0;
            bitcnt <= '0;
          end
        end
        ST_WORD_ACK: begin
          if (scl_fall) begin
            st <= ST_IDLE;
            oe <= 1'b0;
          end
        end
        ST_TX: begin
          if (ptr_step) begin
            st  <= ST_TX_ACK;
            oe  <= 1'b0;
            ptr <= addr_next(ptr);
          end else if (scl_fall) begin
            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
            oe     <= ~txreg[BYTE_W-2];
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall && !mack) st <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign rd_addr = ptr;
  assign sda_oe  = oe;

  // R8: drive enable may only move while SCL is low
  a_r8_oe_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(oe));

  // R8: bus released while the master owns the acknowledge bit
  a_r8_free_in_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX_ACK) |-> !oe);

  // R6: pointer wraps at the top of the array
  a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr == '1) |=> ptr == '0);

  // R4: pointer moves only on an address load or a byte step
  a_r4_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(ptr_step || word_load));

  // R11: any START restarts select decoding
  a_r11_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_SEL && bitcnt == '0 && !oe));

  // R2: foreign identifier gets no acknowledge
  a_r2_no_ack_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_end && !sel_id_ok(shreg)) |=> (st == ST_IDLE && !oe));

  // R7: nothing driven while idle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_IDLE) |-> !oe);

  always_comb begin
    a_r11_bitcnt_range: assert (bitcnt <= FULL);
  end

endmodule

// File: rtl/i2c_rdmem_target.sv
module i2c_rdmem_target
  import i2cmem_pkg::*;
#(
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          pl_we_i,
  input  logic [AW-1:0] pl_addr_i,
  input  logic [7:0]    pl_data_i
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [AW-1:0]     rd_addr;
  logic [BYTE_W-1:0] rd_data;

  i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_mem_array #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk     (clk),
    .wr_en   (pl_we_i),
    .wr_addr (pl_addr_i),
    .wr_data (pl_data_i),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  i2c_rd_engine #(.AW(AW)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .sda_oe   (sda_oe_o)
  );

endmodule

// File: tb/i2c_rdmem_target_tb_top.sv
`timescale 1ns/1ps
module i2c_rdmem_target_tb_top;

  localparam int AW = 10;
  localparam int HQ = 8;
  localparam int NVEC = 8;
  // {current_read, address, byte_count}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 10'h000, 3'd1},
    {1'b1, 10'h000, 3'd1},
    {1'b0, 10'h155, 3'd3},
    {1'b1, 10'h000, 3'd2},
    {1'b0, 10'h2A0, 3'd1},
    {1'b0, 10'h3FE, 3'd4},
    {1'b1, 10'h000, 3'd1},
    {1'b0, 10'h0C3, 3'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          m_scl = 1'b1;
  logic          m_sda = 1'b1;
  logic          sda_oe;
  logic          pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0]    pl_data = '0;
  wire           sda_bus = m_sda & ~sda_oe;

  i2c_rdmem_target dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .pl_we_i   (pl_we),
    .pl_addr_i (pl_addr),
    .pl_data_i (pl_data)
  );

  logic [7:0]    ref_mem [1 << AW];
  logic [AW-1:0] ref_ptr;
  int n_chk = 0;
  int n_fail = 0;
  int hi_moves = 0;
  bit done = 1'b0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + (a >> 3)) ^ 8'h5C);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R8 monitor: enable must not move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_scl && sda_oe != oe_prev) hi_moves++;
    oe_prev <= sda_oe;
  end

  task automatic bus_start();
    m_sda = 1'b1; tick(HQ);
    m_scl = 1'b1; tick(HQ);
    m_sda = 1'b0; tick(HQ);
    m_scl = 1'b0; tick(HQ);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HQ);
    m_scl = 1'b1; tick(HQ);
    m_sda = 1'b1; tick(HQ);
  endtask

  task automatic send_bit(input bit b);
    m_sda = b; tick(HQ);
    m_scl = 1'b1; tick(2 * HQ);
    m_scl = 1'b0; tick(HQ);
  endtask

  task automatic recv_bit(output bit b);
    m_sda = 1'b1; tick(HQ);
    m_scl = 1'b1; tick(HQ);
    b = sda_bus; tick(HQ);
    m_scl = 1'b0; tick(HQ);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit x;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(x);
    acked = !x;
  endtask

  // master NACK bit is sampled: the target must have released SDA (R8)
  task automatic recv_byte(input bit ack, output logic [7:0] d);
    bit x;
    for (int i = 0; i < 8; i++) begin
      recv_bit(x);
      d = {d[6:0], x};
    end
    if (ack) send_bit(1'b0);
    else begin
      recv_bit(x);
      check(x == 1'b1, "R8", int'(x), 1);
    end
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(d == ref_mem[ref_ptr], req, int'(d), int'(ref_mem[ref_ptr]));
      ref_ptr = ref_ptr + 1'b1;
    end
  endtask

  task automatic random_read(input logic [AW-1:0] a, input int n, input bit b3,
                             input string req);
    bit ak;
    bus_start();
    send_byte({4'hA, b3, a[9:8], 1'b0}, ak);
    check(ak, "R3", int'(ak), 1);
    send_byte(a[7:0], ak);
    check(ak, "R3", int'(ak), 1);
    bus_start();
    send_byte(8'hA1, ak);
    check(ak, "R3", int'(ak), 1);
    ref_ptr = a;
    read_bytes(n, req);
    bus_stop();
  endtask

  task automatic current_read(input int n, input logic [7:0] sel, input string req);
    bit ak;
    bus_start();
    send_byte(sel | 8'h01, ak);
    check(ak, "R2", int'(ak), 1);
    read_bytes(n, req);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    bit ak, x;
    int ones;
    logic [7:0] d;

    // preload while held in reset
    for (int a = 0; a < (1 << AW); a++) begin
      pl_we = 1'b1;
      pl_addr = AW'(a);
      pl_data = pat(a);
      ref_mem[a] = pat(a);
      tick(1);
    end
    pl_we = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(20);
    check(sda_oe == 1'b0, "R1", int'(sda_oe), 0);

    // R1: pointer starts at zero
    ref_ptr = '0;
    current_read(1, 8'hA1, "R1");

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][13]) current_read(int'(VEC[v][2:0]), 8'hA1, "R4");
      else if (VEC[v][2:0] > 3'd1)
        random_read(VEC[v][12:3], int'(VEC[v][2:0]), 1'b0, "R5");
      else
        random_read(VEC[v][12:3], int'(VEC[v][2:0]), 1'b0, "R3");
    end

    // R6: wrap during sequential and current-address reads
    random_read(10'h3FF, 2, 1'b0, "R6");
    random_read(10'h3FF, 1, 1'b0, "R6");
    current_read(1, 8'hA1, "R6");

    // R2: foreign identifier
    bus_start();
    send_byte(8'hB1, ak);
    check(!ak, "R2", int'(ak), 0);
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      recv_bit(x);
      ones += int'(x);
    end
    check(ones == 8, "R2", ones, 8);
    bus_stop();
    current_read(1, 8'hA1, "R2");

    // R10: page bits and bit 3 ignored where stated
    current_read(1, 8'hAF, "R10");
    random_read(10'h1E7, 1, 1'b1, "R10");

    // R7: extra clocks after NACK without STOP
    bus_start();
    send_byte(8'hA1, ak);
    check(ak, "R7", int'(ak), 1);
    read_bytes(1, "R7");
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      recv_bit(x);
      ones += int'(x);
    end
    check(ones == 9, "R7", ones, 9);
    bus_stop();
    current_read(1, 8'hA1, "R7");

    // R11: START in the middle of a select byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'hA1, ak);
    check(ak, "R11", int'(ak), 1);
    recv_byte(1'b0, d);
    check(d == ref_mem[ref_ptr], "R11", int'(d), int'(ref_mem[ref_ptr]));
    ref_ptr = ref_ptr + 1'b1;
    bus_stop();

    // R9: preload overwrite then read back
    pl_we = 1'b1; pl_addr = 10'h2C7; pl_data = 8'hE3;
    tick(1);
    pl_we = 1'b0;
    ref_mem[10'h2C7] = 8'hE3;
    random_read(10'h2C7, 1, 1'b0, "R9");

    check(hi_moves == 0, "R8", hi_moves, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule